// File: doc/BRIEF.md
# Boundary-Scan Test Access Port with Identification Word

This block is the serial test port of a memory device. A test controller clocks TMS and TDI on TCK. The block walks the standard sixteen-state controller, keeps a 3-bit instruction register, and connects one of three data registers between TDI and TDO. The three data registers are a 1-bit bypass cell, a 32-bit identification word, and a boundary register that sits over the device's generic input pins and data outputs.

In normal operation the data outputs and their enable come straight from the memory core. The EXTEST instruction gives the pads to the boundary register instead. Its holding stage then drives every output bit, and one cell decides whether the data bus drives or floats. SAMPLE/PRELOAD captures the pins while a new pattern shifts in, without changing the pads. TDO is launched on the falling edge of TCK and is enabled only while a shift state is active.

Top module: `bscan_port`

## Requirements
- R1: The controller state advances on each rising TCK from the TMS value, following the standard sixteen-state diagram. TMS held at 1 for five rising edges reaches Test-Logic-Reset from any state, and TMS=1 keeps it there.
- R2: Asynchronous reset and every pass through Test-Logic-Reset select IDCODE. A data scan made straight after that returns the identification word.
- R3: Capture-IR loads 001 into the instruction shift stage. Shift-IR then presents that pattern on TDO, least significant bit first.
- R4: A new instruction shifts in from TDI as 3 bits, least significant bit first. It takes effect only on the edge that leaves Update-IR. While Shift-IR and Exit-IR are active, the instruction already in force still controls the pads.
- R5: The instruction codes are 000 EXTEST, 001 IDCODE, 100 SAMPLE/PRELOAD and 111 BYPASS. The codes 010, 011, 101 and 110 act as BYPASS.
- R6: The identification word has bit 0 = 1, bits 17:1 = parameter ID_TAIL (default 0x0A5A4), bits 23:18 = 101110, bits 28:24 = 01011 and bits 31:29 = 000. It shifts out bit 0 first.
- R7: BYPASS puts a single cell between TDI and TDO. Capture-DR loads 0 into it, so TDO shows 0 first and then TDI delayed by one shift.
- R8: The boundary register has 1+OUT_W+IN_W cells. Cell 0 is the output-enable cell and is shifted out first. Cells 1..OUT_W hold the data outputs and the cells above them hold the inputs. Capture-DR loads the current pad_oe, pad_out and pin_in.
- R9: Under SAMPLE/PRELOAD, captured data shifts out while new data shifts in. Update-DR loads the holding stage, and the pads keep following core_out and core_oe.
- R10: Under EXTEST, pad_out takes the holding cells 1..OUT_W and pad_oe takes holding cell 0. A 1 drives the bus and a 0 floats it.
- R11: TDO and tdo_en change only on falling TCK. tdo_en is 1 only in Shift-IR and Shift-DR. Outside those states TDO is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Mode select, sampled on rising TCK |
| tdi | input | 1 | Serial data in, sampled on rising TCK |
| tdo | output | 1 | Serial data out, launched on falling TCK |
| tdo_en | output | 1 | High while TDO carries shift data |
| pin_in | input | IN_W | Device input pins seen by the boundary register |
| core_out | input | OUT_W | Data output values from the memory core |
| core_oe | input | 1 | Output enable from the memory core |
| pad_out | output | OUT_W | Values sent to the data output pads |
| pad_oe | output | 1 | Data bus drive enable, 1 drives and 0 floats |

## Verification
A wrong controller state shows within one falling edge: tdo_en rises or falls at the wrong time, and TDO shifts the wrong register. A corrupted instruction register shows on the pads at the next Update-IR, or in the first bit of the next data scan: an ID scan starts with 1, a bypass scan starts with 0. A bad holding stage is seen only once EXTEST is in force, on the first rising edge after Update-IR or Update-DR.

// File: rtl/bscan_port.sv
module bscan_port #(
  parameter int          IN_W    = 8,
  parameter int          OUT_W   = 8,
  parameter logic [16:0] ID_TAIL = 17'h0A5A4
) (
  input  logic             tck,
  input  logic             trst_n,
  input  logic             tms,
  input  logic             tdi,
  output logic             tdo,
  output logic             tdo_en,
  input  logic [IN_W-1:0]  pin_in,
  input  logic [OUT_W-1:0] core_out,
  input  logic             core_oe,
  output logic [OUT_W-1:0] pad_out,
  output logic             pad_oe
);
  localparam int BSR_W = 1 + OUT_W + IN_W;
  localparam logic [2:0] OP_EXTEST = 3'b000;
  localparam logic [2:0] OP_IDCODE = 3'b001;
  localparam logic [2:0] OP_SAMPLE = 3'b100;
  localparam logic [31:0] ID_WORD = {3'b000, 5'b01011, 6'b101110, ID_TAIL, 1'b1};

  typedef enum logic [3:0] {
    TLR = 4'h0, RTI = 4'h1, SEL_DR = 4'h2, CAP_DR = 4'h3,
    SH_DR = 4'h4, EX1_DR = 4'h5, PA_DR = 4'h6, EX2_DR = 4'h7,
    UP_DR = 4'h8, SEL_IR = 4'h9, CAP_IR = 4'hA, SH_IR = 4'hB,
    EX1_IR = 4'hC, PA_IR = 4'hD, EX2_IR = 4'hE, UP_IR = 4'hF
  } tap_st_e;

  tap_st_e            state, nxt;
  logic [2:0]         ir, ir_sr;
  logic               byp;
  logic [31:0]        id_sr;
  logic [BSR_W-1:0]   bsr_sr, bsr_hold;

  wire sel_id  = (ir == OP_IDCODE);
  wire extest  = (ir == OP_EXTEST);
  wire sel_bsr = extest || (ir == OP_SAMPLE);
  wire dr_out  = sel_id ? id_sr[0] : (sel_bsr ? bsr_sr[0] : byp);

  assign pad_out = extest ? bsr_hold[OUT_W:1] : core_out;
  assign pad_oe  = extest ? bsr_hold[0]       : core_oe;

  always_comb begin
    case (state)
      TLR:     nxt = tms ? TLR    : RTI;
      RTI:     nxt = tms ? SEL_DR : RTI;
      SEL_DR:  nxt = tms ? SEL_IR : CAP_DR;
      CAP_DR:  nxt = tms ? EX1_DR : SH_DR;
      SH_DR:   nxt = tms ? EX1_DR : SH_DR;
      EX1_DR:  nxt = tms ? UP_DR  : PA_DR;
      PA_DR:   nxt = tms ? EX2_DR : PA_DR;
      EX2_DR:  nxt = tms ? UP_DR  : SH_DR;
      UP_DR:   nxt = tms ? SEL_DR : RTI;
      SEL_IR:  nxt = tms ? TLR    : CAP_IR;
      CAP_IR:  nxt = tms ? EX1_IR : SH_IR;
      SH_IR:   nxt = tms ? EX1_IR : SH_IR;
      EX1_IR:  nxt = tms ? UP_IR  : PA_IR;
      PA_IR:   nxt = tms ? EX2_IR : PA_IR;
      EX2_IR:  nxt = tms ? UP_IR  : SH_IR;
      default: nxt = tms ? SEL_DR : RTI;
    endcase
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      state    <= TLR;
      ir       <= OP_IDCODE;
      ir_sr    <= '0;
      byp      <= 1'b0;
      id_sr    <= '0;
      bsr_sr   <= '0;
      bsr_hold <= '0;
    end else begin
      state <= nxt;
      case (state)
        TLR:    ir    <= OP_IDCODE;
        CAP_IR: ir_sr <= 3'b001;
        SH_IR:  ir_sr <= {tdi, ir_sr[2:1]};
        UP_IR:  ir    <= ir_sr;
        CAP_DR: begin
          if (sel_id)       id_sr  <= ID_WORD;
          else if (sel_bsr) bsr_sr <= {pin_in, pad_out, pad_oe};
          else              byp    <= 1'b0;
        end
        SH_DR: begin
          if (sel_id)       id_sr  <= {tdi, id_sr[31:1]};
          else if (sel_bsr) bsr_sr <= {tdi, bsr_sr[BSR_W-1:1]};
          else              byp    <= tdi;
        end
        UP_DR:  if (sel_bsr) bsr_hold <= bsr_sr;
        default: ;
      endcase
    end
  end

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tdo    <= 1'b0;
      tdo_en <= 1'b0;
    end else begin
      tdo_en <= (state == SH_IR) || (state == SH_DR);
      tdo    <= (state == SH_IR) ? ir_sr[0] : ((state == SH_DR) ? dr_out : 1'b0);
    end
  end
endmodule

// File: rtl/bscan_port_chk.sv
module bscan_port_chk #(
  parameter int OUT_W = 8
) (
  input logic             tck,
  input logic             trst_n,
  input logic             tms,
  input logic [3:0]       state,
  input logic [2:0]       ir,
  input logic [2:0]       ir_sr,
  input logic             byp,
  input logic             tdo,
  input logic             tdo_en,
  input logic [OUT_W-1:0] pad_out,
  input logic             pad_oe,
  input logic [OUT_W-1:0] core_out,
  input logic             core_oe
);
  localparam logic [3:0] S_TLR = 4'h0, S_CAP_DR = 4'h3, S_CAP_IR = 4'hA, S_UP_IR = 4'hF;

  wire byp_class = (ir != 3'b000) && (ir != 3'b001) && (ir != 3'b100);

  AST_TLR_HOLD: assert property (@(posedge tck) disable iff (!trst_n)
    (state == S_TLR && tms) |=> (state == S_TLR)); // R1
  AST_TLR_IDCODE: assert property (@(posedge tck) disable iff (!trst_n)
    (state == S_TLR) |=> (ir == 3'b001)); // R2
  AST_CAPIR_PATTERN: assert property (@(posedge tck) disable iff (!trst_n)
    (state == S_CAP_IR) |=> (ir_sr == 3'b001)); // R3
  AST_IR_AT_UPDATE: assert property (@(posedge tck) disable iff (!trst_n)
    (ir != $past(ir)) |-> ($past(state) == S_UP_IR || $past(state) == S_TLR)); // R4
  AST_BYP_ZERO: assert property (@(posedge tck) disable iff (!trst_n)
    (state == S_CAP_DR && byp_class) |=> (byp == 1'b0)); // R7
  AST_PADS_FOLLOW: assert property (@(posedge tck) disable iff (!trst_n)
    (ir != 3'b000) |-> (pad_out == core_out && pad_oe == core_oe)); // R9
  AST_TDO_QUIET: assert property (@(posedge tck) disable iff (!trst_n)
    (!tdo_en) |-> (tdo == 1'b0)); // R11
endmodule

bind bscan_port bscan_port_chk #(.OUT_W(OUT_W)) u_chk (
  .tck(tck), .trst_n(trst_n), .tms(tms), .state(state), .ir(ir), .ir_sr(ir_sr),
  .byp(byp), .tdo(tdo), .tdo_en(tdo_en), .pad_out(pad_out), .pad_oe(pad_oe),
  .core_out(core_out), .core_oe(core_oe)
);

// File: tb/bscan_port_test.sv
module bscan_port_test;
  localparam int IN_W = 8;
  localparam int OUT_W = 8;
  localparam logic [31:0] ID = {3'b000, 5'b01011, 6'b101110, 17'h0A5A4, 1'b1};
  localparam logic [63:0] DIN = 64'h0000_00C3_96F0_1E2D;
  localparam logic [7:0]  PIN = 8'h5A;
  localparam logic [7:0]  CORE = 8'hC3;
  // code, kind: 0 id, 1 bypass, 2 sample, 3 extest
  localparam logic [4:0] TBL [8] = '{
    {3'd0, 2'd3}, {3'd1, 2'd0}, {3'd2, 2'd1}, {3'd3, 2'd1},
    {3'd4, 2'd2}, {3'd5, 2'd1}, {3'd6, 2'd1}, {3'd7, 2'd1}};

  logic tck = 1'b0, trst_n = 1'b0, tms = 1'b1, tdi = 1'b0;
  logic tdo, tdo_en, core_oe = 1'b1, pad_oe;
  logic [IN_W-1:0]  pin_in = PIN;
  logic [OUT_W-1:0] core_out = CORE, pad_out;
  int checks = 0, fails = 0;

  bscan_port #(.IN_W(IN_W), .OUT_W(OUT_W)) uut (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_en(tdo_en),
    .pin_in(pin_in), .core_out(core_out), .core_oe(core_oe),
    .pad_out(pad_out), .pad_oe(pad_oe));

  always #5 tck = ~tck;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic m, input logic d);
    tms = m; tdi = d;
    @(posedge tck); @(negedge tck); #1;
  endtask

  task automatic scan(input bit irp, input int n, input logic [63:0] din, output logic [63:0] dout);
    dout = '0;
    step(1, 0);
    if (irp) step(1, 0);
    step(0, 0);
    step(0, 0);
    dout[0] = tdo;
    for (int i = 0; i < n; i++) begin
      step(i == n - 1, din[i]);
      if (i < n - 1) dout[i+1] = tdo;
    end
    step(1, 0);
    step(0, 0);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [63:0] o, e;
    repeat (3) @(negedge tck);
    #1;
    chk("R11 reset tdo/tdo_en", {62'd0, tdo, tdo_en}, 64'd0);
    chk("R9 reset pads", {55'd0, pad_out, pad_oe}, {55'd0, CORE, 1'b1});
    trst_n = 1'b1;
    step(0, 0);
    scan(0, 32, 64'd0, o);
    chk("R2 R6 id after reset", o, {32'd0, ID});

    foreach (TBL[r]) begin
      scan(1, 3, {61'd0, TBL[r][4:2]}, o);
      chk("R3 capture-ir pattern", {61'd0, o[2:0]}, 64'd1);
      scan(0, 40, DIN, o);
      case (TBL[r][1:0])
        2'd0:    e = {24'd0, DIN[7:0], ID};
        2'd1:    e = {24'd0, DIN[38:0], 1'b0};
        2'd2:    e = {24'd0, DIN[22:0], PIN, CORE, 1'b1};
        default: e = {24'd0, DIN[22:0], PIN, 8'h00, 1'b0};
      endcase
      chk($sformatf("R5 R6 R7 R8 dr scan code %0d", TBL[r][4:2]), o, e);
      if (TBL[r][1:0] == 2'd3)
        chk("R10 extest pads after update", {55'd0, pad_out, pad_oe}, {55'd0, DIN[31:23]});
    end

    // preload under SAMPLE, then switch to EXTEST
    core_oe = 1'b0; core_out = 8'h81;
    scan(1, 3, 64'd4, o);
    scan(0, 17, {47'd0, 8'h00, 8'h3C, 1'b1}, o);
    chk("R9 pads unchanged after preload", {55'd0, pad_out, pad_oe}, {55'd0, 8'h81, 1'b0});
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    step(0, 0); step(0, 0); step(1, 0);
    chk("R4 old instruction holds in exit-ir", {55'd0, pad_out, pad_oe}, {55'd0, 8'h81, 1'b0});
    step(1, 0);
    chk("R4 still old in update-ir", {55'd0, pad_out, pad_oe}, {55'd0, 8'h81, 1'b0});
    step(0, 0);
    chk("R10 extest drives preloaded bus", {55'd0, pad_out, pad_oe}, {55'd0, 8'h3C, 1'b1});
    scan(0, 17, {47'd0, 8'h00, 8'hA5, 1'b0}, o);
    chk("R8 extest capture sees driven pads", {47'd0, o[16:0]}, {47'd0, PIN, 8'h3C, 1'b1});
    chk("R10 extest enable 0 floats bus", {55'd0, pad_out, pad_oe}, {55'd0, 8'hA5, 1'b0});

    // five ones from Shift-DR return to IDCODE
    step(1, 0); step(0, 0); step(0, 0);
    for (int k = 0; k < 5; k++) step(1, 0);
    step(1, 0);
    chk("R1 pads back to core after reset state", {55'd0, pad_out, pad_oe}, {55'd0, 8'h81, 1'b0});
    step(0, 0);
    scan(0, 32, 64'd0, o);
    chk("R1 R2 id after five ones", o, {32'd0, ID});

    // TDO timing
    step(1, 0); step(0, 0); step(0, 0);
    chk("R11 first id bit and enable", {62'd0, tdo, tdo_en}, 64'd3);
    tms = 1'b0; tdi = 1'b0;
    @(posedge tck); #1;
    chk("R11 tdo held past rising edge", {63'd0, tdo}, 64'd1);
    @(negedge tck); #1;
    chk("R11 tdo moves on falling edge", {63'd0, tdo}, {63'd0, ID[1]});
    step(1, 0); step(1, 0); step(0, 0);
    chk("R11 idle tdo quiet", {62'd0, tdo, tdo_en}, 64'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule